// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides the outcome of a conditional branch from one 32-bit instruction word. It takes apart the branch-control field, the condition-bit selector, the prediction hint and the link flag. It then reads the selected bit of a 32-bit condition register and may decrement a 32-bit count register. From these it reports whether the branch is taken.

The taken, hint and invalid flags are combinational and follow the inputs in the same cycle. The updated count register and the link value are registered. They take new values on the clock edge that ends a cycle in which the valid strobe is high. A mode input marks a branch whose target comes from the count register. Such a branch must not also decrement that register.

Top module: `branch_resolve`

## Requirements
- R1: The 5-bit control field is instruction bits 25..21 and the selector is bits 20..16. Bit 21 is the prediction hint. `hint_o` equals bit 21 while `valid_i` is high, and is 0 otherwise.
- R2: A selector value k reads condition register bit `cr_i[31-k]`. Field f (selector[4:2]) occupies `cr_i[31-4f : 28-4f]`, and its bits in order from the most significant are less-than, greater-than, equal and summary-overflow.
- R3: Control values 0000y, 0001y, 0100y and 0101y decrement the count. The branch is taken when the condition bit equals control bit 24 and the new count is non-zero (bit 22 = 0) or zero (bit 22 = 1).
- R4: Control values 001zy take the branch when the condition bit is 0, and 011zy take it when the bit is 1. The count register is left unchanged.
- R5: Control values 1z00y and 1z01y decrement the count and ignore the condition bit. They are taken when the new count is non-zero (1z00y) or zero (1z01y).
- R6: Control values 1z1zz are always taken and leave the count unchanged.
- R7: A 1 in any z position makes `invalid_o` 1 while `valid_i` is high. An invalid branch is never taken and never changes the count.
- R8: The decrement wraps from 0 to 0xFFFFFFFF, and the zero test applies to the decremented value.
- R9: On a valid cycle `ctr_o` shows the new count one clock later: either `ctr_i` minus 1 or `ctr_i` unchanged. With `valid_i` low, `ctr_o` holds its value.
- R10: When `valid_i` is high and instruction bit 0 is 1, `lr_o` becomes `pc_i + 4` one clock later, whether or not the branch is taken. Otherwise `lr_o` holds.
- R11: With `ctr_mode_i` high, every control value that would decrement the count raises `invalid_o` and leaves the count unchanged.
- R12: After reset `ctr_o` and `lr_o` are 0. With `valid_i` low, `taken_o` and `invalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| ctr_mode_i | input | 1 | Branch target is the count register |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 32 | Instruction address |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Current count register |
| taken_o | output | 1 | Branch taken (combinational) |
| hint_o | output | 1 | Prediction hint (combinational) |
| invalid_o | output | 1 | Reserved encoding or forbidden decrement |
| ctr_o | output | 32 | Registered updated count register |
| lr_o | output | 32 | Registered link value |

## Verification
The taken, hint and invalid flags are due in the same cycle as the stimulus. The bench samples them 1 ns after it drives the inputs on the falling edge. The count and link results are due one clock later, so they are compared at the next falling edge against a model that was advanced at the rising edge in between. Directed cases cover each control group, the wrap, the hold and mode cases, and a long run of random words compares every cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int INSN_W   = 32;
  localparam int CTL_HI   = 25;
  localparam int CTL_LO   = 21;
  localparam int SEL_HI   = 20;
  localparam int SEL_LO   = 16;
  localparam int LINK_POS = 0;
  localparam int SEL_W    = SEL_HI - SEL_LO + 1;

  typedef struct packed {
    logic [3:0]       mode;   // control bits 25..22
    logic             hint;   // bit 21
    logic [SEL_W-1:0] sel;    // bits 20..16
    logic             link;   // bit 0
  } bru_fields_t;

  function automatic logic [31:0] ctr_minus_one(input logic [31:0] c);
    return c - 32'd1;
  endfunction

  function automatic logic [31:0] link_addr(input logic [31:0] pc);
    return pc + 32'd4;
  endfunction

endpackage

// File: rtl/bru_fields.sv
module bru_fields
  import bru_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output bru_fields_t       f
);
  always_comb begin
    f.mode = insn[CTL_HI:CTL_LO+1];
    f.hint = insn[CTL_LO];
    f.sel  = insn[SEL_HI:SEL_LO];
    f.link = insn[LINK_POS];
  end
endmodule

// File: rtl/bru_crbit.sv
module bru_crbit #(
  parameter int CRW = 32,
  localparam int SW = $clog2(CRW)
) (
  input  logic [CRW-1:0] cr,
  input  logic [SW-1:0]  sel,
  output logic           bit_o
);
  logic [CRW-1:0] msb_first;
  for (genvar i = 0; i < CRW; i++) begin : g_flip
    assign msb_first[i] = cr[CRW-1-i];
  end
  assign bit_o = msb_first[sel];
endmodule

// File: rtl/bru_decide.sv
module bru_decide
  import bru_pkg::*;
(
  input  bru_fields_t f,
  input  logic        cond_bit,
  input  logic        ctr_mode,
  input  logic [31:0] ctr_in,
  output logic        uses_ctr,
  output logic        bad_enc,
  output logic        go,
  output logic [31:0] ctr_dec
);
  logic ignore_cond, want_set, want_zero, ctr_ok, cond_ok, z_bad;

  always_comb begin
    ignore_cond = f.mode[3];
    want_set    = f.mode[2];
    uses_ctr    = ~f.mode[1];
    want_zero   = f.mode[0];
    ctr_dec     = ctr_minus_one(ctr_in);
    z_bad = (~f.mode[3] &  f.mode[1] & f.mode[0])
          | ( f.mode[3] &  f.mode[2])
          | ( f.mode[3] &  f.mode[1] & (f.mode[0] | f.hint));
    bad_enc = z_bad | (ctr_mode & uses_ctr);
    ctr_ok  = ~uses_ctr | ((ctr_dec == 32'd0) == want_zero);
    cond_ok = ignore_cond | (cond_bit == want_set);
    go      = ctr_ok & cond_ok & ~bad_enc;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import bru_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic        ctr_mode_i,
  input  logic [31:0] insn_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] cr_i,
  input  logic [31:0] ctr_i,
  output logic        taken_o,
  output logic        hint_o,
  output logic        invalid_o,
  output logic [31:0] ctr_o,
  output logic [31:0] lr_o
);
  bru_fields_t fld;
  logic        cond_bit, uses_ctr, bad_enc, go;
  logic [31:0] ctr_dec;
  logic        dec_fire, link_fire;

  bru_fields u_fields (.insn(insn_i), .f(fld));

  bru_crbit #(.CRW(32)) u_crbit (.cr(cr_i), .sel(fld.sel), .bit_o(cond_bit));

  bru_decide u_decide (
    .f(fld), .cond_bit(cond_bit), .ctr_mode(ctr_mode_i), .ctr_in(ctr_i),
    .uses_ctr(uses_ctr), .bad_enc(bad_enc), .go(go), .ctr_dec(ctr_dec)
  );

  assign dec_fire  = valid_i & uses_ctr & ~bad_enc;
  assign link_fire = valid_i & fld.link;
  assign taken_o   = valid_i & go;
  assign invalid_o = valid_i & bad_enc;
  assign hint_o    = valid_i & fld.hint;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_o <= '0;
      lr_o  <= '0;
    end else begin
      if (valid_i)   ctr_o <= dec_fire ? ctr_dec : ctr_i;
      if (link_fire) lr_o  <= link_addr(pc_i);
    end
  end
endmodule

// File: rtl/bru_checker.sv
module bru_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic        ctr_mode_i,
  input logic [31:0] insn_i,
  input logic [31:0] pc_i,
  input logic [31:0] ctr_i,
  input logic        taken_o,
  input logic        invalid_o,
  input logic [31:0] ctr_o,
  input logic [31:0] lr_o,
  input logic        dec_fire
);
  // R7
  invalid_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> !taken_o);
  // R9
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(ctr_o));
  // R3
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire |=> ctr_o == $past(ctr_i) - 32'd1);
  // R10
  link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[0]) |=> lr_o == $past(pc_i) + 32'd4);
  // R10
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && insn_i[0]) |=> $stable(lr_o));
  // R11
  mode_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ctr_mode_i && !insn_i[23]) |-> invalid_o);
  // R6
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[25:21] == 5'b10100) |-> taken_o);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!taken_o && !invalid_o));
endmodule

bind branch_resolve bru_checker u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ctr_mode_i(ctr_mode_i),
  .insn_i(insn_i), .pc_i(pc_i), .ctr_i(ctr_i), .taken_o(taken_o),
  .invalid_o(invalid_o), .ctr_o(ctr_o), .lr_o(lr_o), .dec_fire(dec_fire)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_i = 0, ctr_mode_i = 0;
  logic [31:0] insn_i = 0, pc_i = 0, cr_i = 0, ctr_i = 0;
  logic        taken_o, hint_o, invalid_o;
  logic [31:0] ctr_o, lr_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_ctr = 0, exp_lr = 0;
  string last_tag = "R12";

  always #5 clk = ~clk;

  branch_resolve uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ctr_mode_i(ctr_mode_i),
    .insn_i(insn_i), .pc_i(pc_i), .cr_i(cr_i), .ctr_i(ctr_i),
    .taken_o(taken_o), .hint_o(hint_o), .invalid_o(invalid_o),
    .ctr_o(ctr_o), .lr_o(lr_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] bo, input logic [4:0] sel,
                                     input logic lk);
    return {6'd19, bo, sel, 5'd0, 10'd528, lk};
  endfunction

  // Behavioural reference: grouped by control pattern.
  task automatic ref_model(input logic [31:0] insn, input logic [31:0] cr,
                           input logic [31:0] ctr, input logic mode,
                           output logic t, output logic b, output logic d);
    logic [4:0] bo;
    logic c, nz;
    int k;
    bo = insn[25:21];
    k  = insn[20:16];
    c  = cr[31 - k];
    nz = (ctr - 32'd1) != 0;
    if (!bo[4] && !bo[2]) begin
      d = 1; b = 0; t = (c == bo[3]) && (bo[1] ? !nz : nz);
    end else if (!bo[4]) begin
      d = 0; b = bo[1]; t = (c == bo[3]);
    end else if (!bo[2]) begin
      d = 1; b = bo[3]; t = bo[1] ? !nz : nz;
    end else begin
      d = 0; b = bo[3] | bo[1] | bo[0]; t = 1;
    end
    if (mode && d) b = 1;
    if (b) begin t = 0; d = 0; end
  endtask

  task automatic step(input string tag, input logic v, input logic mode,
                      input logic [31:0] insn, input logic [31:0] pc,
                      input logic [31:0] cr, input logic [31:0] ctr);
    logic t, b, d;
    @(negedge clk);
    check(last_tag, "ctr_o", ctr_o, exp_ctr);
    check(last_tag, "lr_o", lr_o, exp_lr);
    valid_i = v; ctr_mode_i = mode; insn_i = insn; pc_i = pc; cr_i = cr; ctr_i = ctr;
    #1;
    ref_model(insn, cr, ctr, mode, t, b, d);
    check(tag, "taken_o", {31'd0, taken_o}, {31'd0, v & t});
    check(tag, "invalid_o", {31'd0, invalid_o}, {31'd0, v & b});
    check(tag, "hint_o", {31'd0, hint_o}, {31'd0, v & insn[21]});
    if (v) exp_ctr = d ? ctr - 32'd1 : ctr;
    if (v && insn[0]) exp_lr = pc + 32'd4;
    last_tag = tag;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "ctr_o reset", ctr_o, 32'd0);
    check("R12", "lr_o reset", lr_o, 32'd0);
    check("R12", "taken idle", {31'd0, taken_o}, 32'd0);
    rst_n = 1;
    // R2: cr0 equal bit at cr_i[29]
    step("R2", 1, 0, mk(5'b01100, 5'd2, 0), 32'h100, 32'h2000_0000, 32'd7);
    step("R2", 1, 0, mk(5'b01100, 5'd2, 0), 32'h100, 32'hDFFF_FFFF, 32'd7);
    step("R2", 1, 0, mk(5'b01100, 5'd31, 0), 32'h100, 32'h0000_0001, 32'd7);
    step("R2", 1, 0, mk(5'b01100, 5'd6, 0), 32'h100, 32'h0200_0000, 32'd7);
    // R1 hint
    step("R1", 1, 0, mk(5'b01101, 5'd0, 0), 32'h100, 32'h8000_0000, 32'd7);
    // R3 decrement with condition
    step("R3", 1, 0, mk(5'b00000, 5'd1, 0), 32'h200, 32'h0, 32'd5);
    step("R3", 1, 0, mk(5'b00010, 5'd1, 0), 32'h200, 32'h0, 32'd1);
    step("R3", 1, 0, mk(5'b01000, 5'd1, 0), 32'h200, 32'h4000_0000, 32'd3);
    step("R3", 1, 0, mk(5'b01010, 5'd1, 0), 32'h200, 32'h0, 32'd1);
    // R4 condition only
    step("R4", 1, 0, mk(5'b00100, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    step("R4", 1, 0, mk(5'b01100, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    // R7 z bits
    step("R7", 1, 0, mk(5'b00110, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    step("R7", 1, 0, mk(5'b11000, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    step("R7", 1, 0, mk(5'b10101, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    step("R7", 1, 0, mk(5'b10110, 5'd3, 0), 32'h300, 32'h0, 32'd9);
    // R5 count only
    step("R5", 1, 0, mk(5'b10000, 5'd0, 0), 32'h400, 32'hFFFF_FFFF, 32'd2);
    step("R5", 1, 0, mk(5'b10010, 5'd0, 0), 32'h400, 32'h0, 32'd1);
    step("R5", 1, 0, mk(5'b10010, 5'd0, 0), 32'h400, 32'h0, 32'd2);
    // R6 always
    step("R6", 1, 0, mk(5'b10100, 5'd9, 0), 32'h500, 32'h0, 32'd0);
    // R8 wrap
    step("R8", 1, 0, mk(5'b10000, 5'd0, 0), 32'h600, 32'h0, 32'd0);
    step("R8", 1, 0, mk(5'b10010, 5'd0, 0), 32'h600, 32'h0, 32'd0);
    // R9 no strobe: outputs hold
    step("R9", 0, 0, mk(5'b10000, 5'd0, 1), 32'h700, 32'h0, 32'd50);
    step("R9", 0, 1, mk(5'b00000, 5'd0, 1), 32'h704, 32'h0, 32'd60);
    // R10 link on untaken branch
    step("R10", 1, 0, mk(5'b01100, 5'd0, 1), 32'h800, 32'h0, 32'd4);
    step("R10", 1, 0, mk(5'b10100, 5'd0, 1), 32'hFFFF_FFFC, 32'h0, 32'd4);
    // R11 count-target mode
    step("R11", 1, 1, mk(5'b10000, 5'd0, 0), 32'h900, 32'h0, 32'd8);
    step("R11", 1, 1, mk(5'b01000, 5'd0, 0), 32'h900, 32'hFFFF_FFFF, 32'd8);
    step("R11", 1, 1, mk(5'b10100, 5'd0, 0), 32'h900, 32'h0, 32'd8);
    step("R11", 1, 1, mk(5'b01100, 5'd0, 0), 32'h900, 32'h8000_0000, 32'd8);
    // random sweep over all fields
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ctr_r;
      ctr_r = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : $urandom;
      step("R3", $urandom_range(0, 7) != 0, $urandom_range(0, 3) == 0,
           mk($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 1)),
           $urandom, $urandom, ctr_r);
    end
    step("R9", 0, 0, 32'd0, 32'd0, 32'd0, 32'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule